// File: doc/BRIEF.md
# PFC Supervisor and Soft-Start Sequencer

This block watches a boost power-factor-correction stage through digitized measurements and decides whether the power switch may run. Its inputs are the supply voltage and the scaled output feedback voltage, both as unsigned millivolt codes, a die-temperature code in degrees Celsius, and a flag that reports whether AC input is present. Each protection is a hysteretic detector that changes state only on a clock edge: supply lockout, over-voltage, feedback-low disable, output-ready and thermal shutdown. The switching enable is formed from four of these detectors.

A sequencer builds the startup reference for the voltage loop. Once the supply is valid and AC is present, the reference climbs from zero to 2500 mV in sixteen equal stair steps. It then holds at the final value while the internal proportional loop stays selected. When the feedback first reaches its rated value, a handoff timer runs. At the end of that timer, control passes to the external compensator. Loss of AC, or a supply lockout, drops the reference to zero and restarts the whole sequence from the beginning.

Sequencer states:
- SQ_LOCKOUT: the supply is not valid.
- SQ_AWAIT_AC: the supply is valid and the block waits for AC.
- SQ_RAMP: the stair-step climb.
- SQ_HOLD: the reference is at its final value and the block waits for rated feedback.
- SQ_HANDOFF: the transition timer is running.
- SQ_EXTERNAL: the external compensator is in use.

Sequencer transitions:
- LOCKOUT→AWAIT_AC when the supply becomes valid.
- AWAIT_AC→RAMP when AC is present.
- RAMP→HOLD after the sixteenth step.
- HOLD→HANDOFF when feedback is rated.
- HANDOFF→EXTERNAL when the timer expires.
- Any state→LOCKOUT when the supply is invalid. This transition has first priority.
- Any other state→AWAIT_AC when AC is absent.

Top module: `pfc_supervisor`

## Requirements
- R1: While reset is held and right after it is released, sw_en, rdy_release, ovp_flag and comp_ext_sel are 0, and ss_ref_mv is 0.
- R2: The supply detector becomes valid on the clock edge after vcc_mv >= 12000. It returns to lockout on the edge after vcc_mv < 8500. Between these two values it keeps its state.
- R3: ovp_flag sets on the edge after fb_mv >= 2676 and clears on the edge after fb_mv <= 2500. Between these values it keeps its state.
- R4: The disable detector goes to the disabled state on the edge after fb_mv < 350. It re-enables on the edge after fb_mv >= 451. At reset it is in the disabled state.
- R5: rdy_release (1 = output released/high, 0 = pulled low) goes to 1 on the edge after fb_mv >= 2241. It goes to 0 on the edge after fb_mv < 1640. Between these values it holds.
- R6: The thermal fault sets on the edge after temp_c >= 140 and clears on the edge after temp_c <= 80.
- R7: sw_en is 1 exactly when the supply is valid, the block is not disabled, ovp_flag is 0 and there is no thermal fault.
- R8: Let E0 be the clock edge at which the sequencer, waiting for AC with a valid supply, sees ac_present = 1. After edge E0 + n·STEP_CYC, for n = 0..16, ss_ref_mv equals floor(n·2500/16).
- R9: After the sixteenth step, ss_ref_mv stays at 2500 and comp_ext_sel stays 0 until fb_mv >= 2500 is seen.
- R10: comp_ext_sel (0 = internal proportional loop, 1 = external compensator) goes to 1 exactly HANDOFF_CYC edges after the edge that first sees fb_mv >= 2500 in the hold state.
- R11: On the edge after ac_present = 0, ss_ref_mv is 0 and comp_ext_sel is 0. When AC returns, the ramp restarts from step 0 as in R8.
- R12: A supply lockout forces ss_ref_mv to 0 and comp_ext_sel to 0 by the second edge after the low supply code. This takes priority over the AC condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vcc_mv | input | MV_W | Supply voltage code, mV |
| fb_mv | input | MV_W | Scaled output feedback code, mV |
| temp_c | input | TC_W | Die temperature code, °C |
| ac_present | input | 1 | AC input detected |
| sw_en | output | 1 | Switching enable |
| rdy_release | output | 1 | Ready flag, open-drain style (1 = released) |
| ovp_flag | output | 1 | Over-voltage flag |
| ss_ref_mv | output | REF_W | Soft-start reference code, mV |
| comp_ext_sel | output | 1 | Loop select: 0 internal proportional, 1 external |

## Verification
The hardest case to reach is loss of AC while the handoff timer is already counting. To get there, the block must first finish a full ramp and then see rated feedback, and the AC flag must drop partway through the transition window. The bench runs the complete ramp with short step and handoff parameters, raises feedback to the rated code, and removes AC halfway through the timer. It then confirms that the reference falls to zero with the internal loop still selected. Finally, it lets a second full ramp and handoff complete and checks the exact edge at which the external compensator is selected.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

    // Detector thresholds: set when code >= *_SET, clear when code < *_CLR
    localparam int unsigned UV_SET   = 12000;
    localparam int unsigned UV_CLR   = 8500;
    localparam int unsigned OVP_SET  = 2676;
    localparam int unsigned OVP_CLR  = 2501;
    localparam int unsigned EN_SET   = 451;
    localparam int unsigned EN_CLR   = 350;
    localparam int unsigned RDY_SET  = 2241;
    localparam int unsigned RDY_CLR  = 1640;
    localparam int unsigned TS_SET   = 140;
    localparam int unsigned TS_CLR   = 81;

    // Soft-start reference
    localparam int unsigned REF_FINAL = 2500;
    localparam int unsigned SS_STEPS  = 16;

    typedef enum logic [2:0] {
        SQ_LOCKOUT  = 3'd0,
        SQ_AWAIT_AC = 3'd1,
        SQ_RAMP     = 3'd2,
        SQ_HOLD     = 3'd3,
        SQ_HANDOFF  = 3'd4,
        SQ_EXTERNAL = 3'd5
    } seq_state_e;

endpackage

// File: rtl/pfc_hyst_det.sv
module pfc_hyst_det #(
    parameter int unsigned W      = 16,
    parameter int unsigned SET_TH = 100,
    parameter int unsigned CLR_TH = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code,
    output logic         active
);

    localparam logic [W-1:0] SET_C = W'(SET_TH);
    localparam logic [W-1:0] CLR_C = W'(CLR_TH);

    logic active_n;

    always_comb begin
        active_n = active;
        if (code >= SET_C) begin
            active_n = 1'b1;
        end else if (code < CLR_C) begin
            active_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else begin
            active <= active_n;
        end
    end

endmodule

// File: rtl/pfc_ss_seq.sv
module pfc_ss_seq
    import pfc_sup_pkg::*;
#(
    parameter int unsigned STEPS       = 16,
    parameter int unsigned STEP_CYC    = 39062,
    parameter int unsigned HANDOFF_CYC = 3750000,
    parameter int unsigned REF_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             ac_present,
    input  logic             fb_rated,
    output logic [REF_W-1:0] ref_o,
    output logic             ext_sel_o
);

    localparam int unsigned CMAX = (STEP_CYC > HANDOFF_CYC) ? STEP_CYC : HANDOFF_CYC;
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam int unsigned SW   = $clog2(STEPS + 1);

    seq_state_e      st, st_n;
    logic [CW-1:0]   cnt, cnt_n;
    logic [SW-1:0]   step, step_n;

    // Next-state and counter logic
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        step_n = step;
        if (!supply_ok) begin
            st_n   = SQ_LOCKOUT;
            cnt_n  = '0;
            step_n = '0;
        end else if (!ac_present) begin
            st_n   = SQ_AWAIT_AC;
            cnt_n  = '0;
            step_n = '0;
        end else begin
            unique case (st)
                SQ_LOCKOUT: begin
                    st_n = SQ_AWAIT_AC;
                end
                SQ_AWAIT_AC: begin
                    st_n   = SQ_RAMP;
                    cnt_n  = '0;
                    step_n = '0;
                end
                SQ_RAMP: begin
                    if (cnt == CW'(STEP_CYC - 1)) begin
                        cnt_n  = '0;
                        step_n = step + 1'b1;
                        if (step == SW'(STEPS - 1)) begin
                            st_n = SQ_HOLD;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                SQ_HOLD: begin
                    if (fb_rated) begin
                        st_n  = SQ_HANDOFF;
                        cnt_n = '0;
                    end
                end
                SQ_HANDOFF: begin
                    if (cnt == CW'(HANDOFF_CYC - 1)) begin
                        st_n  = SQ_EXTERNAL;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                SQ_EXTERNAL: begin
                    st_n = SQ_EXTERNAL;
                end
                default: begin
                    st_n   = SQ_LOCKOUT;
                    cnt_n  = '0;
                    step_n = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SQ_LOCKOUT;
            cnt  <= '0;
            step <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            step <= step_n;
        end
    end

    // Outputs
    always_comb begin
        ref_o     = REF_W'((32'(step) * REF_FINAL) / STEPS);
        ext_sel_o = (st == SQ_EXTERNAL);
    end

endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
    import pfc_sup_pkg::*;
#(
    parameter int unsigned MV_W        = 16,
    parameter int unsigned TC_W        = 8,
    parameter int unsigned REF_W       = 12,
    parameter int unsigned STEP_CYC    = 39062,
    parameter int unsigned HANDOFF_CYC = 3750000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MV_W-1:0]   vcc_mv,
    input  logic [MV_W-1:0]   fb_mv,
    input  logic [TC_W-1:0]   temp_c,
    input  logic              ac_present,
    output logic              sw_en,
    output logic              rdy_release,
    output logic              ovp_flag,
    output logic [REF_W-1:0]  ss_ref_mv,
    output logic              comp_ext_sel
);

    logic supply_ok, en_ok, ovp_q, rdy_q, ts_fault, fb_rated;

    pfc_hyst_det #(.W(MV_W), .SET_TH(UV_SET), .CLR_TH(UV_CLR)) u_uv (
        .clk(clk), .rst_n(rst_n), .code(vcc_mv), .active(supply_ok));

    pfc_hyst_det #(.W(MV_W), .SET_TH(OVP_SET), .CLR_TH(OVP_CLR)) u_ovp (
        .clk(clk), .rst_n(rst_n), .code(fb_mv), .active(ovp_q));

    pfc_hyst_det #(.W(MV_W), .SET_TH(EN_SET), .CLR_TH(EN_CLR)) u_en (
        .clk(clk), .rst_n(rst_n), .code(fb_mv), .active(en_ok));

    pfc_hyst_det #(.W(MV_W), .SET_TH(RDY_SET), .CLR_TH(RDY_CLR)) u_rdy (
        .clk(clk), .rst_n(rst_n), .code(fb_mv), .active(rdy_q));

    pfc_hyst_det #(.W(TC_W), .SET_TH(TS_SET), .CLR_TH(TS_CLR)) u_ts (
        .clk(clk), .rst_n(rst_n), .code(temp_c), .active(ts_fault));

    assign fb_rated = (fb_mv >= MV_W'(REF_FINAL));

    pfc_ss_seq #(
        .STEPS(SS_STEPS), .STEP_CYC(STEP_CYC),
        .HANDOFF_CYC(HANDOFF_CYC), .REF_W(REF_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .ac_present(ac_present), .fb_rated(fb_rated),
        .ref_o(ss_ref_mv), .ext_sel_o(comp_ext_sel));

    always_comb begin
        sw_en       = supply_ok & en_ok & ~ovp_q & ~ts_fault;
        rdy_release = rdy_q;
        ovp_flag    = ovp_q;
    end

endmodule

// File: rtl/pfc_supervisor_chk.sv
module pfc_supervisor_chk
    import pfc_sup_pkg::*;
#(
    parameter int unsigned MV_W  = 16,
    parameter int unsigned TC_W  = 8,
    parameter int unsigned REF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [MV_W-1:0]  vcc_mv,
    input logic [MV_W-1:0]  fb_mv,
    input logic [TC_W-1:0]  temp_c,
    input logic             ac_present,
    input logic             sw_en,
    input logic             rdy_release,
    input logic             ovp_flag,
    input logic [REF_W-1:0] ss_ref_mv,
    input logic             comp_ext_sel
);

    p_uv_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_mv < MV_W'(UV_CLR)) |=> !sw_en);

    p_ovp_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovp_flag) |-> ($past(fb_mv) >= MV_W'(OVP_SET)));

    p_ovp_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovp_flag) |-> ($past(fb_mv) < MV_W'(OVP_CLR)));

    p_dis_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_mv < MV_W'(EN_CLR)) |=> !sw_en);

    p_rdy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_release) |-> ($past(fb_mv) >= MV_W'(RDY_SET)));

    p_rdy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_release) |-> ($past(fb_mv) < MV_W'(RDY_CLR)));

    p_ts_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_c >= TC_W'(TS_SET)) |=> !sw_en);

    p_ovp_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_flag |-> !sw_en);

    p_ref_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_ref_mv <= REF_W'(REF_FINAL));

    p_ref_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ss_ref_mv) |-> ((ss_ref_mv > $past(ss_ref_mv)) || (ss_ref_mv == '0)));

    p_ext_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
        comp_ext_sel |-> (ss_ref_mv == REF_W'(REF_FINAL)));

    p_ac_loss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ac_present |=> ((ss_ref_mv == '0) && !comp_ext_sel));

    p_uv_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_mv < MV_W'(UV_CLR)) |-> ##2 ((ss_ref_mv == '0) && !comp_ext_sel));

endmodule

bind pfc_supervisor pfc_supervisor_chk #(
    .MV_W(MV_W), .TC_W(TC_W), .REF_W(REF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vcc_mv(vcc_mv), .fb_mv(fb_mv),
    .temp_c(temp_c), .ac_present(ac_present), .sw_en(sw_en),
    .rdy_release(rdy_release), .ovp_flag(ovp_flag),
    .ss_ref_mv(ss_ref_mv), .comp_ext_sel(comp_ext_sel)
);

// File: tb/test_pfc_supervisor.sv
module test_pfc_supervisor;

    localparam int SC = 8;
    localparam int HC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] vcc_mv = '0;
    logic [15:0] fb_mv = '0;
    logic [7:0]  temp_c = 8'd25;
    logic        ac_present = 1'b0;
    logic        sw_en, rdy_release, ovp_flag, comp_ext_sel;
    logic [11:0] ss_ref_mv;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pfc_supervisor #(
        .MV_W(16), .TC_W(8), .REF_W(12), .STEP_CYC(SC), .HANDOFF_CYC(HC)
    ) i_pfc_supervisor (
        .clk(clk), .rst_n(rst_n), .vcc_mv(vcc_mv), .fb_mv(fb_mv),
        .temp_c(temp_c), .ac_present(ac_present), .sw_en(sw_en),
        .rdy_release(rdy_release), .ovp_flag(ovp_flag),
        .ss_ref_mv(ss_ref_mv), .comp_ext_sel(comp_ext_sel));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int ref_at(input int n);
        return (n * 2500) / 16;
    endfunction

    task automatic t_reset();
        step(2);
        check("R1 sw_en", sw_en, 0);
        check("R1 rdy", rdy_release, 0);
        check("R1 ovp", ovp_flag, 0);
        check("R1 ref", ss_ref_mv, 0);
        check("R1 sel", comp_ext_sel, 0);
        rst_n = 1'b1;
        step(1);
        check("R1 sw_en after release", sw_en, 0);
        check("R1 ref after release", ss_ref_mv, 0);
    endtask

    task automatic t_uvlo();
        fb_mv = 16'd1000;
        vcc_mv = 16'd11999; step(1);
        check("R2 below start", sw_en, 0);
        vcc_mv = 16'd12000; step(1);
        check("R2 at start", sw_en, 1);
        vcc_mv = 16'd8500; step(1);
        check("R2 at stop holds", sw_en, 1);
        vcc_mv = 16'd8499; step(1);
        check("R2 below stop", sw_en, 0);
        vcc_mv = 16'd11999; step(1);
        check("R2 hysteresis holds off", sw_en, 0);
        vcc_mv = 16'd14000; step(1);
        check("R2 restart", sw_en, 1);
    endtask

    task automatic t_disable();
        fb_mv = 16'd350; step(1);
        check("R4 at 350 stays enabled", sw_en, 1);
        fb_mv = 16'd349; step(1);
        check("R4 below 350 disables", sw_en, 0);
        fb_mv = 16'd450; step(1);
        check("R4 at 450 stays disabled", sw_en, 0);
        fb_mv = 16'd451; step(1);
        check("R4 re-enable", sw_en, 1);
    endtask

    task automatic t_ovp();
        fb_mv = 16'd2675; step(1);
        check("R3 at 2675 no ovp", ovp_flag, 0);
        fb_mv = 16'd2676; step(1);
        check("R3 trip", ovp_flag, 1);
        check("R7 ovp gates enable", sw_en, 0);
        fb_mv = 16'd2501; step(1);
        check("R3 2501 holds", ovp_flag, 1);
        fb_mv = 16'd2500; step(1);
        check("R3 release", ovp_flag, 0);
        check("R7 enable back", sw_en, 1);
    endtask

    task automatic t_ready();
        fb_mv = 16'd1639; step(1);
        check("R5 low", rdy_release, 0);
        fb_mv = 16'd2240; step(1);
        check("R5 2240 still low", rdy_release, 0);
        fb_mv = 16'd2241; step(1);
        check("R5 set", rdy_release, 1);
        fb_mv = 16'd1640; step(1);
        check("R5 1640 holds", rdy_release, 1);
        fb_mv = 16'd1639; step(1);
        check("R5 clear", rdy_release, 0);
    endtask

    task automatic t_thermal();
        fb_mv = 16'd1000;
        temp_c = 8'd139; step(1);
        check("R6 139 no fault", sw_en, 1);
        temp_c = 8'd140; step(1);
        check("R6 trip", sw_en, 0);
        temp_c = 8'd81; step(1);
        check("R6 81 holds", sw_en, 0);
        temp_c = 8'd80; step(1);
        check("R6 release", sw_en, 1);
        temp_c = 8'd25;
    endtask

    // Enter ramp from AWAIT_AC; returns positioned mid-step-0
    task automatic start_ramp();
        ac_present = 1'b1;
        step(1);
        step(SC / 2);
    endtask

    task automatic t_ramp();
        start_ramp();
        check("R8 step 0", ss_ref_mv, 0);
        for (int n = 1; n <= 16; n++) begin
            step(SC);
            check("R8 step", ss_ref_mv, ref_at(n));
        end
        check("R8 final 2500", ss_ref_mv, 2500);
        step(3 * SC);
        check("R9 hold ref", ss_ref_mv, 2500);
        check("R9 hold internal", comp_ext_sel, 0);
    endtask

    task automatic t_handoff();
        fb_mv = 16'd2500;
        step(HC);
        check("R10 before handoff", comp_ext_sel, 0);
        step(1);
        check("R10 external", comp_ext_sel, 1);
        check("R10 ref final", ss_ref_mv, 2500);
    endtask

    task automatic t_ac_loss();
        ac_present = 1'b0; step(1);
        check("R11 ref reset", ss_ref_mv, 0);
        check("R11 internal", comp_ext_sel, 0);
        fb_mv = 16'd1000;
        start_ramp();
        step(3 * SC);
        check("R8 mid ramp step 3", ss_ref_mv, ref_at(3));
        ac_present = 1'b0; step(1);
        check("R11 mid ramp reset", ss_ref_mv, 0);
        step(2 * SC);
        check("R11 waits while absent", ss_ref_mv, 0);
        start_ramp();
        check("R11 restart step 0", ss_ref_mv, 0);
        step(SC);
        check("R11 restart step 1", ss_ref_mv, ref_at(1));
    endtask

    // AC lost while the handoff timer is running
    task automatic t_loss_in_handoff();
        step(15 * SC);
        check("R8 ramp done", ss_ref_mv, 2500);
        fb_mv = 16'd2500;
        step(HC / 2);
        check("R10 mid handoff internal", comp_ext_sel, 0);
        ac_present = 1'b0; step(1);
        check("R11 loss in handoff ref", ss_ref_mv, 0);
        check("R11 loss in handoff sel", comp_ext_sel, 0);
        start_ramp();
        step(16 * SC);
        check("R8 second ramp final", ss_ref_mv, 2500);
        // HOLD entered at E0+16SC, handoff at E0+16SC+1; now at E0+16SC+SC/2
        step(HC - SC / 2);
        check("R10 second handoff pending", comp_ext_sel, 0);
        step(1);
        check("R10 second handoff done", comp_ext_sel, 1);
    endtask

    task automatic t_uv_restart();
        vcc_mv = 16'd8000; step(1);
        check("R2 lockout", sw_en, 0);
        step(1);
        check("R12 ref zero", ss_ref_mv, 0);
        check("R12 internal", comp_ext_sel, 0);
        vcc_mv = 16'd14000; step(3);
        check("R12 restart from zero", ss_ref_mv, 0);
        check("R7 enable after restart", sw_en, 1);
    endtask

    initial begin
        t_reset();
        t_uvlo();
        t_disable();
        t_ovp();
        t_ready();
        t_thermal();
        t_ramp();
        t_handoff();
        t_ac_loss();
        t_loss_in_handoff();
        t_uv_restart();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule